// File: doc/BRIEF.md
# LIN Sync Field Bit-Time Meter

This block times the synchronisation byte that follows a LIN break, so that software can work out the bit rate the bus master is using. A validated break arms it. From the first falling edge of the sync byte up to the fifth falling edge, it counts pulses of a fixed time-base enable that does not depend on the core clock or on the current baud setting. Those four falling-edge intervals cover eight bit periods. The count is stored in a read-only measurement register, a completion flag and an interrupt are raised, and the block goes back to idle.

A second output gives one bit period, which is the stored count divided by eight with rounding. If the counter would wrap before the last edge arrives, the block reports a sync error and leaves the measurement register as it was. A fresh break strobe always restarts the measurement, whatever state the block is in. The block does not compute a UART divisor.

Top module: `lin_sync_timer`

## Requirements
- R1: After reset, the measurement register reads 0, the status word reads 0, `irq_o` is low and `bit_time_o` is 0.
- R2: Without a prior break strobe, falling edges on `rx_i` change neither the measurement register nor the status word.
- R3: A falling edge is a clock edge at which `rx_i` is sampled 0 and its previous sample was 1. The stored count equals the number of `tick_i` pulses sampled at the clock edges after the edge that registered the first fall, up to and including the edge that registered the fifth fall.
- R4: One cycle after the fifth fall, `irq_o` is high for exactly one cycle. At the end of that cycle the count is stored and the done bit is set. After that the block is idle and ignores falling edges until the next break.
- R5: `bit_time_o` equals (stored count + 4) >> 3.
- R6: A tick that arrives while the counter already holds its maximum value (2^CNT_W - 1) ends the measurement. It sets the sync-error bit, raises no interrupt and leaves the measurement register unchanged. The done and error bits are never both set.
- R7: A `brk_i` strobe in any state clears both status bits and re-arms the block. A falling edge sampled in the same cycle as the strobe does not count as the first fall.
- R8: The read port returns the measurement register when `rd_addr_i` is 0. When it is 1, it returns the status word: bit 0 is done, bit 1 is sync error, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_i | input | 1 | Receive line, already synchronised to `clk` |
| brk_i | input | 1 | One-cycle strobe for a validated break |
| tick_i | input | 1 | Enable pulse of the fixed time base |
| rd_addr_i | input | 1 | Register select: 0 selects the measurement, 1 selects the status |
| rd_data_o | output | CNT_W | Read data |
| bit_time_o | output | CNT_W-2 | Rounded count divided by eight |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
Several properties are checked on every cycle by assertions. A break always leads to the armed state, and the completion state and the interrupt last one cycle each. The fall counter stays inside its range, the done and error flags exclude each other, and the counter holds its value after an overflow. The measurement register also changes only when leaving the completion state. Only the bench scenarios can show that the stored count matches the tick count over the four intervals. They sweep bit periods and tick rates, cover the rounding of the bit time, show that edges before a break and after completion are ignored, and exercise restart by a break mid-frame and a break that coincides with a fall.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } sync_state_e;
endpackage

// File: rtl/lin_sync_fall.sv
module lin_sync_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_i;
  end

  assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/lin_sync_tmr.sv
module lin_sync_tmr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ovf_o = en_i & tick_i & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                       cnt_d = '0;
    else if (en_i && tick_i && !ovf_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> $stable(cnt_q));
endmodule

// File: rtl/lin_sync_ctrl.sv
module lin_sync_ctrl
  import lin_sync_pkg::*;
#(
  parameter int SYNC_FALLS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        brk_i,
  input  logic        fall_i,
  input  logic        ovf_i,
  output sync_state_e state_o,
  output logic        clr_o,
  output logic        cnt_en_o,
  output logic        fin_o,
  output logic        err_o
);
  localparam int             EW   = (SYNC_FALLS > 2) ? $clog2(SYNC_FALLS) : 1;
  localparam logic [EW-1:0]  LAST = EW'(SYNC_FALLS - 2);

  sync_state_e   state_q, state_d;
  logic [EW-1:0] edge_q, edge_d;

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    if (brk_i) begin
      state_d = ST_ARMED;
      edge_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_ARMED: if (fall_i) begin
                    state_d = ST_COUNT;
                    edge_d  = '0;
                  end
        ST_COUNT: if (ovf_i) begin
                    state_d = ST_IDLE;
                  end else if (fall_i) begin
                    if (edge_q == LAST) state_d = ST_DONE;
                    else                edge_d  = edge_q + 1'b1;
                  end
        ST_DONE:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
    end
  end

  assign state_o  = state_q;
  assign clr_o    = (state_q == ST_ARMED) & fall_i & ~brk_i;
  assign cnt_en_o = (state_q == ST_COUNT);
  assign fin_o    = (state_q == ST_DONE) & ~brk_i;
  assign err_o    = (state_q == ST_COUNT) & ovf_i & ~brk_i;

  // R7
  brk_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> (state_q == ST_ARMED));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q != ST_DONE));

  // R3
  edge_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= LAST);
endmodule

// File: rtl/lin_sync_timer.sv
module lin_sync_timer
  import lin_sync_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SYNC_FALLS = 5
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       rx_i,
  input  logic                                       brk_i,
  input  logic                                       tick_i,
  input  logic                                       rd_addr_i,
  output logic [CNT_W-1:0]                           rd_data_o,
  output logic [CNT_W-$clog2(2*(SYNC_FALLS-1)):0]    bit_time_o,
  output logic                                       irq_o
);
  localparam int SHIFT = $clog2(2 * (SYNC_FALLS - 1));
  localparam logic [CNT_W:0] HALF = (CNT_W + 1)'(1 << (SHIFT - 1));

  logic             fall;
  logic             clr, cnt_en, fin, err, ovf;
  logic [CNT_W-1:0] cnt;
  sync_state_e      state;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             done_q, done_d, err_q, err_d;
  logic [CNT_W:0]   rnd;

  lin_sync_fall u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .fall_o (fall)
  );

  lin_sync_ctrl #(.SYNC_FALLS(SYNC_FALLS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .brk_i    (brk_i),
    .fall_i   (fall),
    .ovf_i    (ovf),
    .state_o  (state),
    .clr_o    (clr),
    .cnt_en_o (cnt_en),
    .fin_o    (fin),
    .err_o    (err)
  );

  lin_sync_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .en_i   (cnt_en),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  always_comb begin
    meas_d = meas_q;
    done_d = done_q;
    err_d  = err_q;
    if (brk_i) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (fin) begin
        meas_d = cnt;
        done_d = 1'b1;
      end
      if (err) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      meas_q <= meas_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign rnd        = {1'b0, meas_q} + HALF;
  assign bit_time_o = rnd[CNT_W:SHIFT];
  assign irq_o      = (state == ST_DONE);
  assign rd_data_o  = rd_addr_i ? {{(CNT_W-2){1'b0}}, err_q, done_q} : meas_q;

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_q, err_q}));

  // R4
  meas_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_q) |-> $past(state == ST_DONE));

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: tb/sim_lin_sync_timer.sv
module sim_lin_sync_timer;
  localparam int W   = 10;
  localparam int MAX = (1 << W) - 1;

  logic         clk, rst_n, rx_i, brk_i, tick_i, rd_addr_i, irq_o;
  logic [W-1:0] rd_data_o;
  logic [W-3:0] bit_time_o;

  int n_tot, n_bad, gcyc, tper, irq_bad;
  int m_ph, m_cnt, m_nf, m_meas, m_done, m_err, m_irq, m_prev;

  lin_sync_timer #(.CNT_W(W), .SYNC_FALLS(5)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .brk_i(brk_i), .tick_i(tick_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .bit_time_o(bit_time_o),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output int v);
    rd_addr_i = a;
    #1;
    v = int'(rd_data_o);
  endtask

  // one clock cycle of stimulus plus the reference model of the requirements
  task automatic drive(input logic rx, input logic bk);
    int fall;
    @(negedge clk);
    if (int'(irq_o) != m_irq) irq_bad++;
    rx_i   = rx;
    brk_i  = bk;
    tick_i = ((gcyc % tper) == 0);
    @(posedge clk);
    fall = (m_prev == 1 && rx == 1'b0) ? 1 : 0;
    if (bk) begin
      m_ph = 1; m_cnt = 0; m_nf = 0; m_done = 0; m_err = 0;
    end else begin
      case (m_ph)
        1: if (fall == 1) begin m_ph = 2; m_cnt = 0; m_nf = 1; end
        2: begin
             if (tick_i && m_cnt == MAX) begin
               m_err = 1; m_ph = 0;
             end else begin
               if (tick_i) m_cnt++;
               if (fall == 1) begin
                 m_nf++;
                 if (m_nf == 5) m_ph = 3;
               end
             end
           end
        3: begin m_meas = m_cnt; m_done = 1; m_ph = 0; end
        default: ;
      endcase
    end
    m_irq  = (m_ph == 3) ? 1 : 0;
    m_prev = int'(rx);
    gcyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0);
  endtask

  // start bit, 0x55 LSB first, stop bit: five falling edges, 2p cycles apart
  task automatic send_sync(input int p, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      logic lv;
      lv = (b == 0) ? 1'b0 : ((b == 9) ? 1'b1 : ((b % 2) == 1));
      for (int c = 0; c < p; c++) drive(lv, 1'b0);
    end
  endtask

  task automatic check_regs(input string req);
    int v;
    rd(1'b0, v);
    chk({req, " meas"}, v, m_meas);
    rd(1'b1, v);
    chk({req, " status"}, v, m_done + 2 * m_err);
    chk("R5 bit_time", int'(bit_time_o), (m_meas + 4) >> 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  end

  initial begin
    int v;
    int plist [7] = '{3, 4, 5, 7, 9, 13, 16};
    n_tot = 0; n_bad = 0; gcyc = 0; tper = 1; irq_bad = 0;
    m_ph = 0; m_cnt = 0; m_nf = 0; m_meas = 0; m_done = 0; m_err = 0;
    m_irq = 0; m_prev = 1;
    rst_n = 1'b0; rx_i = 1'b1; brk_i = 1'b0; tick_i = 1'b0; rd_addr_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); chk("R1 meas", v, 0);
    rd(1'b1, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 bit_time", int'(bit_time_o), 0);

    // R2 sync byte with no break before it
    idle(2); send_sync(4, 10); idle(3);
    rd(1'b0, v); chk("R2 meas", v, 0);
    rd(1'b1, v); chk("R2 status", v, 0);

    // R3 R5 sweep of bit periods and tick rates
    for (int t = 1; t <= 3; t++) begin
      for (int i = 0; i < 7; i++) begin
        tper = t;
        drive(1'b1, 1'b1); idle(2);
        send_sync(plist[i], 10); idle(3);
        check_regs("R3");
        if (t == 1) begin
          rd(1'b0, v); chk("R3 eight periods", v, 8 * plist[i]);
        end
      end
    end
    chk("R4 irq pattern", irq_bad, 0);

    // R4 edges after completion are ignored
    tper = 1;
    drive(1'b1, 1'b1); idle(2); send_sync(6, 10); idle(3);
    rd(1'b0, v); chk("R4 meas", v, 48);
    send_sync(3, 10); idle(3);
    rd(1'b0, v); chk("R4 ignored edges", v, 48);
    rd(1'b1, v); chk("R4 done kept", v, 1);

    // R6 overflow: 8*140 ticks exceed 1023
    drive(1'b1, 1'b1); idle(2); send_sync(140, 10); idle(3);
    rd(1'b0, v); chk("R6 meas kept", v, 48);
    rd(1'b1, v); chk("R6 error status", v, 2);
    check_regs("R6");
    chk("R6 no irq", irq_bad, 0);

    // R7 break in mid-frame restarts the measurement
    drive(1'b1, 1'b1); idle(2); send_sync(5, 5);
    drive(1'b1, 1'b1); idle(2); send_sync(6, 10); idle(3);
    rd(1'b0, v); chk("R7 restart meas", v, 48);
    rd(1'b1, v); chk("R7 restart status", v, 1);

    // R7 break coinciding with a fall: that fall is not the first edge
    drive(1'b1, 1'b1); idle(2);
    drive(1'b0, 1'b1); for (int c = 0; c < 4; c++) drive(1'b0, 1'b0);
    idle(3); send_sync(5, 10); idle(3);
    rd(1'b0, v); chk("R7 coincident fall", v, 40);
    check_regs("R7");

    // R7 break clears a set error flag
    drive(1'b1, 1'b1); idle(2); send_sync(140, 10); idle(2);
    rd(1'b1, v); chk("R7 error set", v, 2);
    drive(1'b1, 1'b1); idle(1);
    rd(1'b1, v); chk("R7 break clears", v, 0);

    // R8 read port select, with rounding of a non-multiple of eight
    tper = 3;
    drive(1'b1, 1'b1); idle(2); send_sync(7, 10); idle(3);
    check_regs("R8");
    chk("R4 R6 irq final", irq_bad, 0);

    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  end
endmodule